// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Controller

This block holds the interrupt bookkeeping for the 32 message buffers of a CAN-style controller. Each buffer has one flag and one enable bit. When the protocol engine reports that a buffer has finished a transfer, the flag for that buffer is set. The report is the same for transmit and receive. Software clears a flag by writing a one to its position. A single registered interrupt line is raised whenever any enabled flag is set.

When receive-FIFO mode is on, the lowest eight flag positions take on a different meaning. Position 7 reports FIFO overflow, position 6 reports the FIFO almost-full warning and position 5 reports that frames are waiting. Positions 4 to 0 stay at zero. In this mode the three FIFO flags are driven by dedicated event pulses, and the buffer completion pulses for buffers 0 to 7 are dropped.

Software reaches the flag and enable words through a small register port. Select 0 is the flag word, where writing a one clears that bit. Select 1 is the enable word, an ordinary read/write register. Reads are combinational.

Top module: `mbflag_ctrl`

## Requirements
- R1: After reset the flag word reads 0x00000000, the enable word reads 0x00000000 and `irq_out` is low.
- R2: In normal mode (`fifo_mode`=0), a one on `buf_done[n]` in a cycle sets flag bit n at that clock edge. Any pattern of bits may be set together.
- R3: A write with `reg_sel`=0 clears every flag bit where `reg_wdata` holds a one. Bits where `reg_wdata` holds a zero keep their value.
- R4: If a set event and a write-one clear hit the same flag bit in the same cycle, that bit ends up set.
- R5: A write with `reg_sel`=1 loads the enable word, and the enable word reads back unchanged. Writes with `reg_sel`=0 leave the enable word unchanged.
- R6: `irq_out` is registered. It is high in the cycle after the bitwise AND of the flag and enable words is non-zero, and low in the cycle after it is zero.
- R7: In FIFO mode, `fifo_ovf_ev` sets bit 7, `fifo_warn_ev` sets bit 6 and `fifo_avail_ev` sets bit 5. In normal mode these three inputs have no effect.
- R8: In FIFO mode, `buf_done[7:0]` has no effect and flag bits 4 to 0 read as zero. Bits 31 to 8 still follow `buf_done`.
- R9: A change of `fifo_mode` clears flag bits 7 to 0 at the next edge and leaves bits 31 to 8 unchanged.
- R10: The FIFO flags feed `irq_out` through their enable bits, in the same way as buffer flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode | input | 1 | 1 gives the low eight flags their FIFO meaning |
| buf_done | input | 32 | Completion pulse for each buffer |
| fifo_ovf_ev | input | 1 | FIFO overflow event pulse |
| fifo_warn_ev | input | 1 | FIFO warning event pulse |
| fifo_avail_ev | input | 1 | FIFO frames-available event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag word, 1 selects the enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
Completion patterns are tried in both modes, starting from a cleared flag word each time:
- a single low bit, a single top bit and a dense mixed word. These separate per-bit wiring faults from shifted or merged bits.
- all eight low completions in FIFO mode, with and without the FIFO events. This shows whether the low buffer pulses leak through.
- each FIFO event on its own. This confirms the position of each FIFO flag.
- the FIFO events in normal mode, which must have no effect.

Directed sequences then cover the following:
- a partial write-one clear;
- a clear in the same cycle as a set;
- enable isolation;
- the one-cycle interrupt lag on both rising and falling edges;
- the low-byte wipe on a mode switch.

// File: rtl/mbflag_pkg.sv
package mbflag_pkg;
  localparam int BUF_CNT   = 32;
  localparam int FIFO_SPAN = 8;
  localparam int OVF_POS   = 7;
  localparam int WARN_POS  = 6;
  localparam int AVAIL_POS = 5;

  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_EN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mbflag_setmap.sv
module mbflag_setmap #(
  parameter int NUM_BUF   = 32,
  parameter int FIFO_SPAN = 8,
  parameter int OVF_POS   = 7,
  parameter int WARN_POS  = 6,
  parameter int AVAIL_POS = 5
) (
  input  logic               fifo_mode,
  input  logic [NUM_BUF-1:0] buf_done,
  input  logic [2:0]         fifo_ev,   // {ovf, warn, avail}
  output logic [NUM_BUF-1:0] set_vec
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_bit
    if (i == OVF_POS) begin : g_ovf
      assign set_vec[i] = fifo_mode ? fifo_ev[2] : buf_done[i];
    end else if (i == WARN_POS) begin : g_warn
      assign set_vec[i] = fifo_mode ? fifo_ev[1] : buf_done[i];
    end else if (i == AVAIL_POS) begin : g_avail
      assign set_vec[i] = fifo_mode ? fifo_ev[0] : buf_done[i];
    end else if (i < FIFO_SPAN) begin : g_low
      assign set_vec[i] = fifo_mode ? 1'b0 : buf_done[i];
    end else begin : g_high
      assign set_vec[i] = buf_done[i];
    end
  end
endmodule

// File: rtl/mbflag_store.sv
module mbflag_store #(
  parameter int NUM_BUF   = 32,
  parameter int FIFO_SPAN = 8,
  parameter int AVAIL_POS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_mode,
  input  logic               mode_chg,
  input  logic [NUM_BUF-1:0] set_vec,
  input  logic [NUM_BUF-1:0] clr_vec,
  output logic [NUM_BUF-1:0] flags_q
);
  function automatic logic [NUM_BUF-1:0] low_ones(input int n);
    logic [NUM_BUF-1:0] m;
    for (int k = 0; k < NUM_BUF; k++) m[k] = (k < n);
    return m;
  endfunction

  localparam logic [NUM_BUF-1:0] SPAN_M   = low_ones(FIFO_SPAN);
  localparam logic [NUM_BUF-1:0] UNUSED_M = low_ones(AVAIL_POS);

  // set wins over clear on the same bit
  function automatic logic [NUM_BUF-1:0] next_flags(
    input logic [NUM_BUF-1:0] cur,
    input logic [NUM_BUF-1:0] setv,
    input logic [NUM_BUF-1:0] clrv,
    input logic               fmode,
    input logic               chg
  );
    logic [NUM_BUF-1:0] n;
    n = (cur & ~clrv) | setv;
    if (fmode) n = n & ~UNUSED_M;
    if (chg)   n = n & ~SPAN_M;
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= next_flags(flags_q, set_vec, clr_vec, fifo_mode, mode_chg);
  end
endmodule

// File: rtl/mbflag_irq.sv
module mbflag_irq #(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [NUM_BUF-1:0] wdata,
  input  logic [NUM_BUF-1:0] flags_q,
  output logic [NUM_BUF-1:0] mask_q,
  output logic               irq_q
);
  function automatic logic any_pending(input logic [NUM_BUF-1:0] f,
                                       input logic [NUM_BUF-1:0] m);
    return |(f & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      irq_q <= any_pending(flags_q, mask_q);
    end
  end
endmodule

// File: rtl/mbflag_ctrl.sv
module mbflag_ctrl #(
  parameter int NUM_BUF   = mbflag_pkg::BUF_CNT,
  parameter int FIFO_SPAN = mbflag_pkg::FIFO_SPAN,
  parameter int OVF_POS   = mbflag_pkg::OVF_POS,
  parameter int WARN_POS  = mbflag_pkg::WARN_POS,
  parameter int AVAIL_POS = mbflag_pkg::AVAIL_POS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_mode,
  input  logic [NUM_BUF-1:0] buf_done,
  input  logic               fifo_ovf_ev,
  input  logic               fifo_warn_ev,
  input  logic               fifo_avail_ev,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [NUM_BUF-1:0] reg_wdata,
  output logic [NUM_BUF-1:0] reg_rdata,
  output logic               irq_out
);
  import mbflag_pkg::*;

  logic               mode_q;
  logic               mode_chg;
  logic               mask_we;
  logic [NUM_BUF-1:0] set_vec;
  logic [NUM_BUF-1:0] clr_vec;
  logic [NUM_BUF-1:0] flags_q;
  logic [NUM_BUF-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end

  assign mode_chg = fifo_mode ^ mode_q;
  assign mask_we  = reg_wr && (reg_sel == SEL_EN);
  assign clr_vec  = (reg_wr && (reg_sel == SEL_FLAG)) ? reg_wdata : '0;

  mbflag_setmap #(
    .NUM_BUF(NUM_BUF), .FIFO_SPAN(FIFO_SPAN),
    .OVF_POS(OVF_POS), .WARN_POS(WARN_POS), .AVAIL_POS(AVAIL_POS)
  ) setmap_i (
    .fifo_mode (fifo_mode),
    .buf_done  (buf_done),
    .fifo_ev   ({fifo_ovf_ev, fifo_warn_ev, fifo_avail_ev}),
    .set_vec   (set_vec)
  );

  mbflag_store #(
    .NUM_BUF(NUM_BUF), .FIFO_SPAN(FIFO_SPAN), .AVAIL_POS(AVAIL_POS)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .mode_chg  (mode_chg),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .flags_q   (flags_q)
  );

  mbflag_irq #(.NUM_BUF(NUM_BUF)) irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (mask_we),
    .wdata   (reg_wdata),
    .flags_q (flags_q),
    .mask_q  (mask_q),
    .irq_q   (irq_out)
  );

  assign reg_rdata = (reg_sel == SEL_EN) ? mask_q : flags_q;
endmodule

// File: rtl/mbflag_ctrl_chk.sv
module mbflag_ctrl_chk #(
  parameter int NUM_BUF = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_q,
  input logic               mode_chg,
  input logic               mask_we,
  input logic [NUM_BUF-1:0] set_vec,
  input logic [NUM_BUF-1:0] clr_vec,
  input logic [NUM_BUF-1:0] flags_q,
  input logic [NUM_BUF-1:0] mask_q,
  input logic               irq_out
);
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0 && !mode_chg) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  p_clear_works_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0));

  p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0 && !mode_chg) |=>
      ((flags_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  p_mask_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  p_irq_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(flags_q & mask_q))));

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (flags_q[4:0] == 5'd0));

  p_mode_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (flags_q[7:0] == 8'd0));
endmodule

bind mbflag_ctrl mbflag_ctrl_chk #(.NUM_BUF(NUM_BUF)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_q   (mode_q),
  .mode_chg (mode_chg),
  .mask_we  (mask_we),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .flags_q  (flags_q),
  .mask_q   (mask_q),
  .irq_out  (irq_out)
);

// File: tb/mbflag_ctrl_tb_top.sv
module mbflag_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b0;
  logic [31:0] buf_done = '0;
  logic        fifo_ovf_ev = 1'b0, fifo_warn_ev = 1'b0, fifo_avail_ev = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mbflag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .buf_done(buf_done),
    .fifo_ovf_ev(fifo_ovf_ev), .fifo_warn_ev(fifo_warn_ev), .fifo_avail_ev(fifo_avail_ev),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  typedef struct packed {
    logic        mode;
    logic [31:0] done;
    logic [2:0]  fev;   // {ovf, warn, avail}
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0001, 3'b000, 32'h0000_0001},
    '{1'b0, 32'h8000_0000, 3'b000, 32'h8000_0000},
    '{1'b0, 32'hA5A5_00FF, 3'b000, 32'hA5A5_00FF},
    '{1'b1, 32'h0000_00FF, 3'b000, 32'h0000_0000},
    '{1'b1, 32'h1234_56FF, 3'b111, 32'h1234_56E0},
    '{1'b1, 32'h0000_0000, 3'b100, 32'h0000_0080},
    '{1'b1, 32'h0000_0000, 3'b010, 32'h0000_0040},
    '{1'b1, 32'h0000_0000, 3'b001, 32'h0000_0020},
    '{1'b0, 32'h0000_0000, 3'b111, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_word(input logic sel, output logic [31:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] d, input logic [2:0] fev);
    @(negedge clk);
    buf_done = d; {fifo_ovf_ev, fifo_warn_ev, fifo_avail_ev} = fev;
    @(negedge clk);
    buf_done = '0; {fifo_ovf_ev, fifo_warn_ev, fifo_avail_ev} = 3'b000;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_word(1'b0, v); check("R1 flags after reset", v, 32'h0);
    read_word(1'b1, v); check("R1 enable after reset", v, 32'h0);
    check("R1 irq after reset", {31'd0, irq_out}, 32'h0);

    // vector table: R2, R7, R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); fifo_mode = VECS[i].mode;
      repeat (2) @(negedge clk);
      reg_write(1'b0, 32'hFFFF_FFFF);
      pulse(VECS[i].done, VECS[i].fev);
      read_word(1'b0, v);
      check($sformatf("R2/R7/R8 vector %0d", i), v, VECS[i].exp);
    end
    @(negedge clk); fifo_mode = 1'b0;
    repeat (2) @(negedge clk);
    reg_write(1'b0, 32'hFFFF_FFFF);

    // R3 partial clear
    pulse(32'hF0F0_F0F0, 3'b000);
    reg_write(1'b0, 32'h00F0_0000);
    read_word(1'b0, v); check("R3 partial clear", v, 32'hF000_F0F0);

    // R4 set and clear same cycle
    @(negedge clk);
    buf_done = 32'h0000_1001; reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    buf_done = '0; reg_wr = 1'b0; reg_wdata = '0;
    read_word(1'b0, v); check("R4 set beats clear", v, 32'h0000_1001);
    reg_write(1'b0, 32'hFFFF_FFFF);

    // R5 enable register
    reg_write(1'b1, 32'h0000_0100);
    read_word(1'b1, v); check("R5 enable readback", v, 32'h0000_0100);
    reg_write(1'b0, 32'hFFFF_FFFF);
    read_word(1'b1, v); check("R5 enable kept on flag write", v, 32'h0000_0100);

    // R6 interrupt lag
    pulse(32'h0000_0200, 3'b000);
    @(negedge clk);
    check("R6 unmasked flag no irq", {31'd0, irq_out}, 32'h0);
    reg_write(1'b0, 32'h0000_0200);
    @(negedge clk);
    buf_done = 32'h0000_0100;
    @(negedge clk);
    buf_done = '0;
    check("R6 irq one cycle after flag", {31'd0, irq_out}, 32'h0);
    @(negedge clk);
    check("R6 irq raised", {31'd0, irq_out}, 32'h1);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_0100;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    check("R6 irq still high at clear edge", {31'd0, irq_out}, 32'h1);
    @(negedge clk);
    check("R6 irq drops", {31'd0, irq_out}, 32'h0);

    // R10 FIFO flag drives irq
    fifo_mode = 1'b1;
    repeat (2) @(negedge clk);
    reg_write(1'b1, 32'h0000_0080);
    pulse(32'h0, 3'b100);
    @(negedge clk);
    check("R10 fifo overflow irq", {31'd0, irq_out}, 32'h1);
    reg_write(1'b0, 32'h0000_0080);
    @(negedge clk);
    check("R10 irq cleared", {31'd0, irq_out}, 32'h0);

    // R9 mode switch wipes low byte only
    pulse(32'h0100_0000, 3'b111);
    read_word(1'b0, v); check("R9 before switch", v, 32'h0100_00E0);
    @(negedge clk); fifo_mode = 1'b0;
    @(negedge clk);
    read_word(1'b0, v); check("R9 low byte wiped", v, 32'h0100_0000);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule